// File: doc/BRIEF.md
# Switch-point task relocation controller

This block wraps a hardware task so that an operating system can pre-empt it and move it to a processor, or bring it back from state the processor produced. A relocation request may be raised at any moment, but the task keeps running until it reports that it has reached one of its designer-placed switch-points. The controller then freezes the task and streams out a header followed by the state words that belong to that switch-point. When the last word has gone it pulses a done flag, and the task stays parked.

A parked task can be brought back in one of two ways. The first is a restore stream in the same format: the controller checks the header word count against a per-switch-point table, writes the words into the task's state, restarts the task and tells it which switch-point to continue from. The second is a plain start command, which releases a freshly configured task with no restore. Switch-points differ in the amount of state they carry, from zero to fifteen 32-bit words. A switch-point placed where nothing needs to be kept, such as a frame boundary, carries only the header.

Top module: `swpt_reloc_ctrl`

## Requirements
- R1: After reset the task is parked: `task_run`, `sv_valid`, `rsm_go` and `rs_err` are 0. A `go_cmd` pulse while parked raises `task_run` from the next cycle.
- R2: After a `reloc_req` pulse the task keeps running (`task_run` stays 1) for as long as no switch-point is reported.
- R3: A `sp_hit` pulse while no request is pending has no effect. `task_run` stays 1 and no save stream starts.
- R4: A `sp_hit` pulse with a request pending drops `task_run` from the next cycle, and a save stream starts with a header word. The header holds the switch-point ID in bits [2:0] and the word count in bits [11:8], with all other bits 0. The default counts for IDs 0..7 are 0, 3, 1, 15, 2, 0, 5, 4.
- R5: After the header, the save stream carries exactly the counted words. Save word k (0-based) is the `st_word` value presented while `st_idx` = k. While `sv_valid` is high and `sv_ready` is low, the stream word is held.
- R6: `sv_done` pulses for one cycle in the cycle after the last save word is accepted. A zero-count switch-point sends the header alone and is then followed by `sv_done`.
- R7: A `reloc_req` that arrives during a save or while parked is ignored and is not remembered. After a later resume, a switch-point does not stop the task.
- R8: While parked, a restore header whose count matches the table is accepted and is followed by N words. Each of these words appears on `ld_we`/`ld_idx`/`ld_data`, with `ld_idx` running 0..N-1. After the last word, `task_run` rises and `rsm_go` pulses for one cycle with `rsm_id` equal to the header ID.
- R9: A restore header that matches a zero-count entry resumes the task directly in the cycle after the header, with no load writes.
- R10: A restore header whose count differs from the table sets `rs_err`, keeps the task parked and writes nothing. The flag clears when a matching header is accepted or on `go_cmd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reloc_req | input | 1 | Relocation request pulse from the operating system |
| go_cmd | input | 1 | Start a parked task without restore |
| task_run | output | 1 | Task may advance when high |
| sp_hit | input | 1 | Task has reached a switch-point (pulse) |
| sp_id | input | 3 | ID of the reported switch-point |
| st_idx | output | 4 | Index of the task state word to present on `st_word` |
| st_word | input | 32 | Task state word selected by `st_idx` |
| rsm_go | output | 1 | Pulse: resume at switch-point `rsm_id` |
| rsm_id | output | 3 | Switch-point to resume from |
| sv_valid | output | 1 | Save stream word valid |
| sv_ready | input | 1 | Save stream consumer ready |
| sv_data | output | 32 | Save stream word |
| sv_done | output | 1 | Pulse after the last save word |
| rs_valid | input | 1 | Restore stream word valid |
| rs_ready | output | 1 | Controller accepts restore words |
| rs_data | input | 32 | Restore stream word |
| ld_we | output | 1 | Write a restored word into the task |
| ld_idx | output | 4 | Index of the restored word |
| ld_data | output | 32 | Restored word |
| rs_err | output | 1 | Restore header count mismatch |

## Verification
The assertions assume that the task's state words do not change while the task is frozen. They also assume that `sp_hit` is a single-cycle pulse. The bench models the task's state as a fixed function of `st_idx` and drives every pulse input for exactly one cycle. Requests are deliberately fired while a stream is stalled and while the task is parked, and a stall is inserted in the middle of a restore stream. Both the zero-word and the fifteen-word switch-points are exercised, and mismatched headers are always sent on their own, with no trailing words.

// File: rtl/reloc_pkg.sv
// Shared types for the switch-point relocation controller.
package reloc_pkg;
    typedef enum logic [2:0] {
        ST_RUN  = 3'd0,
        ST_PEND = 3'd1,
        ST_SAVE = 3'd2,
        ST_HALT = 3'd3,
        ST_RSTR = 3'd4
    } rl_state_t;
endpackage

// File: rtl/reloc_sp_table.sv
// Switch-point word-count lookup.
// Decodes a packed parameter of per-ID counts and returns the count for one ID.
// Assumes: entry g occupies bits [g*CNT_W +: CNT_W] of SP_WORDS.
module reloc_sp_table #(
    parameter int unsigned ID_W  = 3,
    parameter int unsigned CNT_W = 4,
    parameter logic [(CNT_W << ID_W)-1:0] SP_WORDS = 32'h4502F130
) (
    input  logic [ID_W-1:0]  id,
    output logic [CNT_W-1:0] cnt
);
    localparam int unsigned NUM_SP = 1 << ID_W;

    logic [CNT_W-1:0] entry [NUM_SP];

    // Split the packed table into one entry per switch-point.
    for (genvar g = 0; g < NUM_SP; g++) begin : g_ent
        assign entry[g] = SP_WORDS[g*CNT_W +: CNT_W];
    end

    assign cnt = entry[id];
endmodule

// File: rtl/reloc_save_port.sv
// Save stream engine.
// Sends a header (ID, count), then the counted task state words, on a valid/ready stream.
// Pulses done one cycle after the last word. Assumes the task holds st_word stable while frozen.
module reloc_save_port #(
    parameter int unsigned ID_W        = 3,
    parameter int unsigned CNT_W       = 4,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned HDR_CNT_LSB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              active,
    input  logic [ID_W-1:0]   id_in,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              sv_ready,
    input  logic [DATA_W-1:0] st_word,
    output logic              sv_valid,
    output logic [DATA_W-1:0] sv_data,
    output logic [CNT_W-1:0]  st_idx,
    output logic              last_xfer,
    output logic              sv_done
);
    logic [ID_W-1:0]   id_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  pos_q;
    logic [DATA_W-1:0] hdr_word;
    logic              xfer;

    assign xfer      = active && sv_ready;
    assign sv_valid  = active;
    assign last_xfer = xfer && (pos_q == cnt_q);
    assign st_idx    = (pos_q == '0) ? '0 : pos_q - 1'b1;
    assign sv_data   = (pos_q == '0) ? hdr_word : st_word;

    // Build the header word from the latched ID and count.
    always_comb begin
        hdr_word = '0;
        hdr_word[ID_W-1:0] = id_q;
        hdr_word[HDR_CNT_LSB +: CNT_W] = cnt_q;
    end

    // Latch the switch-point on start and step through the words on each handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q  <= '0;
            cnt_q <= '0;
            pos_q <= '0;
        end else if (start) begin
            id_q  <= id_in;
            cnt_q <= cnt_in;
            pos_q <= '0;
        end else if (xfer) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    // One-cycle completion pulse after the last word.
    always_ff @(posedge clk) begin
        if (!rst_n) sv_done <= 1'b0;
        else        sv_done <= last_xfer;
    end
endmodule

// File: rtl/reloc_load_port.sv
// Restore word loader.
// After an accepted header, forwards the counted restore words to the task state, one per handshake.
// Assumes the loaded count is non-zero whenever active is high.
module reloc_load_port #(
    parameter int unsigned CNT_W  = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              active,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              rs_valid,
    input  logic [DATA_W-1:0] rs_data,
    output logic              ld_we,
    output logic [CNT_W-1:0]  ld_idx,
    output logic [DATA_W-1:0] ld_data,
    output logic              last_xfer
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] pos_q;

    assign ld_we     = active && rs_valid;
    assign ld_idx    = pos_q;
    assign ld_data   = rs_data;
    assign last_xfer = ld_we && (pos_q == cnt_q - 1'b1);

    // Capture the expected count at the header and advance on each written word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pos_q <= '0;
        end else if (start) begin
            cnt_q <= cnt_in;
            pos_q <= '0;
        end else if (ld_we) begin
            pos_q <= pos_q + 1'b1;
        end
    end
endmodule

// File: rtl/swpt_reloc_ctrl.sv
// Switch-point task relocation controller (top).
// Sequences run, pending, save, parked and restore phases around a hardware task.
// Assumes: sp_hit is a one-cycle pulse; the task advances only while task_run is high;
// on rsm_go the task continues from switch-point rsm_id using the words it was loaded with.
module swpt_reloc_ctrl #(
    parameter int unsigned ID_W        = 3,
    parameter int unsigned CNT_W       = 4,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned HDR_CNT_LSB = 8,
    parameter logic [(CNT_W << ID_W)-1:0] SP_WORDS = 32'h4502F130
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reloc_req,
    input  logic              go_cmd,
    output logic              task_run,
    input  logic              sp_hit,
    input  logic [ID_W-1:0]   sp_id,
    output logic [CNT_W-1:0]  st_idx,
    input  logic [DATA_W-1:0] st_word,
    output logic              rsm_go,
    output logic [ID_W-1:0]   rsm_id,
    output logic              sv_valid,
    input  logic              sv_ready,
    output logic [DATA_W-1:0] sv_data,
    output logic              sv_done,
    input  logic              rs_valid,
    output logic              rs_ready,
    input  logic [DATA_W-1:0] rs_data,
    output logic              ld_we,
    output logic [CNT_W-1:0]  ld_idx,
    output logic [DATA_W-1:0] ld_data,
    output logic              rs_err
);
    import reloc_pkg::*;

    rl_state_t        state_q, state_d;
    logic [CNT_W-1:0] sv_tbl_cnt, rs_tbl_cnt;
    logic [ID_W-1:0]  rs_hdr_id;
    logic [CNT_W-1:0] rs_hdr_cnt;
    logic             save_start, sv_last, ld_last;
    logic             hdr_xfer, hdr_ok, hdr_zero;

    assign rs_hdr_id  = rs_data[ID_W-1:0];
    assign rs_hdr_cnt = rs_data[HDR_CNT_LSB +: CNT_W];

    assign task_run   = (state_q == ST_RUN) || (state_q == ST_PEND);
    assign save_start = (state_q == ST_PEND) && sp_hit;
    assign rs_ready   = ((state_q == ST_HALT) && !go_cmd) || (state_q == ST_RSTR);
    assign hdr_xfer   = (state_q == ST_HALT) && !go_cmd && rs_valid;
    assign hdr_ok     = hdr_xfer && (rs_hdr_cnt == rs_tbl_cnt);
    assign hdr_zero   = hdr_ok && (rs_hdr_cnt == '0);

    reloc_sp_table #(.ID_W(ID_W), .CNT_W(CNT_W), .SP_WORDS(SP_WORDS)) i_tbl_sv (
        .id  (sp_id),
        .cnt (sv_tbl_cnt)
    );

    reloc_sp_table #(.ID_W(ID_W), .CNT_W(CNT_W), .SP_WORDS(SP_WORDS)) i_tbl_rs (
        .id  (rs_hdr_id),
        .cnt (rs_tbl_cnt)
    );

    reloc_save_port #(
        .ID_W(ID_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .HDR_CNT_LSB(HDR_CNT_LSB)
    ) i_save (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (save_start),
        .active    (state_q == ST_SAVE),
        .id_in     (sp_id),
        .cnt_in    (sv_tbl_cnt),
        .sv_ready  (sv_ready),
        .st_word   (st_word),
        .sv_valid  (sv_valid),
        .sv_data   (sv_data),
        .st_idx    (st_idx),
        .last_xfer (sv_last),
        .sv_done   (sv_done)
    );

    reloc_load_port #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_load (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (hdr_ok),
        .active    (state_q == ST_RSTR),
        .cnt_in    (rs_hdr_cnt),
        .rs_valid  (rs_valid),
        .rs_data   (rs_data),
        .ld_we     (ld_we),
        .ld_idx    (ld_idx),
        .ld_data   (ld_data),
        .last_xfer (ld_last)
    );

    // Next-state selection for the relocation sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (reloc_req) state_d = ST_PEND;
            ST_PEND: if (sp_hit)    state_d = ST_SAVE;
            ST_SAVE: if (sv_last)   state_d = ST_HALT;
            ST_HALT: begin
                if (go_cmd)        state_d = ST_RUN;
                else if (hdr_zero) state_d = ST_RUN;
                else if (hdr_ok)   state_d = ST_RSTR;
            end
            ST_RSTR: if (ld_last)   state_d = ST_RUN;
            default: state_d = ST_HALT;
        endcase
    end

    // State register; reset parks the task.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // Resume pulse and resume target, taken from an accepted restore header.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsm_go <= 1'b0;
            rsm_id <= '0;
        end else begin
            rsm_go <= hdr_zero || ld_last;
            if (hdr_ok) rsm_id <= rs_hdr_id;
        end
    end

    // Restore error flag: set on a count mismatch, cleared by a good header or a start.
    always_ff @(posedge clk) begin
        if (!rst_n)                             rs_err <= 1'b0;
        else if ((state_q == ST_HALT) && go_cmd) rs_err <= 1'b0;
        else if (hdr_xfer)                      rs_err <= !hdr_ok;
    end
endmodule

// File: rtl/swpt_reloc_ctrl_chk.sv
// Property checker for the relocation controller, bound into every instance of the top.
// Assumes the frozen task keeps st_word stable and sp_hit lasts one cycle.
module swpt_reloc_ctrl_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 go_cmd,
    input logic                 sp_hit,
    input logic                 task_run,
    input logic                 sv_valid,
    input logic                 sv_ready,
    input logic [DATA_W-1:0]    sv_data,
    input logic                 sv_done,
    input logic                 rs_valid,
    input logic                 rs_err,
    input logic                 rsm_go,
    input logic                 ld_we,
    input reloc_pkg::rl_state_t state_q
);
    import reloc_pkg::*;

    p_pend_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && !sp_hit) |=> task_run);

    p_stray_sp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && sp_hit) |=> task_run);

    p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && sp_hit) |=> (!task_run && sv_valid));

    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sv_valid && !sv_ready) |=> (sv_valid && $stable(sv_data)));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sv_done |=> !sv_done);

    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sv_done |-> (!sv_valid && !task_run));

    p_park_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !go_cmd && !rs_valid) |=> !task_run);

    p_resume_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsm_go |-> task_run);

    p_load_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we |-> !task_run);

    p_err_parked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rs_err |-> !task_run);
endmodule

bind swpt_reloc_ctrl swpt_reloc_ctrl_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_swpt_reloc_ctrl.sv
// Directed bench for the switch-point relocation controller.
module test_swpt_reloc_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reloc_req = 1'b0, go_cmd = 1'b0;
    logic        task_run;
    logic        sp_hit = 1'b0;
    logic [2:0]  sp_id = '0;
    logic [3:0]  st_idx;
    logic [31:0] st_word;
    logic        rsm_go;
    logic [2:0]  rsm_id;
    logic        sv_valid, sv_done;
    logic        sv_ready = 1'b0;
    logic [31:0] sv_data;
    logic        rs_valid = 1'b0;
    logic        rs_ready;
    logic [31:0] rs_data = '0;
    logic        ld_we;
    logic [3:0]  ld_idx;
    logic [31:0] ld_data;
    logic        rs_err;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    // Task state model: a fixed word per index.
    assign st_word = {28'h5A00000, st_idx};

    swpt_reloc_ctrl i_swpt_reloc_ctrl (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    function automatic logic [31:0] hdr(input int id, input int n);
        return (32'(n) << 8) | 32'(id);
    endfunction

    task automatic req_pulse;
        reloc_req = 1'b1; tick; reloc_req = 1'b0;
    endtask

    task automatic hit_sp(input int id);
        sp_hit = 1'b1; sp_id = 3'(id); tick; sp_hit = 1'b0;
        chk("R4 task frozen", 32'(task_run), 0);
        chk("R4 save starts", 32'(sv_valid), 1);
    endtask

    task automatic collect(input int id, input int n);
        for (int k = 0; k <= n; k++) begin
            chk("R5 valid", 32'(sv_valid), 1);
            if (k == 0) chk("R4 header", sv_data, hdr(id, n));
            else        chk("R5 word", sv_data, 32'h5A000000 + 32'(k - 1));
            sv_ready = 1'b1;
            tick;
        end
        sv_ready = 1'b0;
        chk("R6 done pulse", 32'(sv_done), 1);
        chk("R6 stream idle", 32'(sv_valid), 0);
        tick;
        chk("R6 done single", 32'(sv_done), 0);
    endtask

    task automatic do_restore(input int id, input int n);
        rs_valid = 1'b1; rs_data = hdr(id, n);
        #1 chk("R8 header ready", 32'(rs_ready), 1);
        tick;
        for (int k = 0; k < n; k++) begin
            if (k == 1) begin
                rs_valid = 1'b0;
                #1 chk("R8 gap no write", 32'(ld_we), 0);
                tick;
                rs_valid = 1'b1;
            end
            rs_data = 32'hB0000000 + 32'(id * 16 + k);
            #1 chk("R8 load we", 32'(ld_we), 1);
            chk("R8 load idx", 32'(ld_idx), 32'(k));
            chk("R8 load data", ld_data, 32'hB0000000 + 32'(id * 16 + k));
            tick;
        end
        rs_valid = 1'b0;
        chk(n == 0 ? "R9 resumed" : "R8 resumed", 32'(task_run), 1);
        chk("R8 resume pulse", 32'(rsm_go), 1);
        chk("R8 resume id", 32'(rsm_id), 32'(id));
        tick;
        chk("R8 resume single", 32'(rsm_go), 0);
    endtask

    task automatic t_reset;
        repeat (3) tick;
        rst_n = 1'b1;
        tick;
        chk("R1 parked", 32'(task_run), 0);
        chk("R1 no save", 32'(sv_valid), 0);
        chk("R1 no err", 32'(rs_err), 0);
        chk("R1 no resume", 32'(rsm_go), 0);
        go_cmd = 1'b1; tick; go_cmd = 1'b0;
        chk("R1 started", 32'(task_run), 1);
    endtask

    task automatic t_stray_sp;
        sp_hit = 1'b1; sp_id = 3'd3; tick; sp_hit = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R3 still running", 32'(task_run), 1);
            chk("R3 no save", 32'(sv_valid), 0);
            tick;
        end
    endtask

    task automatic t_save_basic;
        req_pulse;
        for (int i = 0; i < 3; i++) begin
            chk("R2 runs until point", 32'(task_run), 1);
            tick;
        end
        hit_sp(1);
        chk("R4 header first", sv_data, hdr(1, 3));
        reloc_req = 1'b1; tick; reloc_req = 1'b0;
        chk("R5 stall hold", sv_data, hdr(1, 3));
        chk("R5 stall valid", 32'(sv_valid), 1);
        collect(1, 3);
        req_pulse;
        for (int i = 0; i < 3; i++) begin
            chk("R7 parked ignores req", 32'(task_run), 0);
            chk("R7 no new save", 32'(sv_valid), 0);
            tick;
        end
    endtask

    task automatic t_restore_basic;
        do_restore(1, 3);
        sp_hit = 1'b1; sp_id = 3'd1; tick; sp_hit = 1'b0;
        chk("R7 request not kept", 32'(task_run), 1);
        chk("R7 no save after resume", 32'(sv_valid), 0);
    endtask

    task automatic t_zero;
        req_pulse;
        hit_sp(5);
        collect(5, 0);
        do_restore(5, 0);
    endtask

    task automatic t_mismatch;
        req_pulse; hit_sp(2); collect(2, 1);
        rs_valid = 1'b1; rs_data = hdr(3, 2); tick; rs_valid = 1'b0;
        chk("R10 err set", 32'(rs_err), 1);
        chk("R10 stays parked", 32'(task_run), 0);
        #1 chk("R10 no write", 32'(ld_we), 0);
        tick;
        chk("R10 still parked", 32'(task_run), 0);
        do_restore(2, 1);
        chk("R10 err cleared by header", 32'(rs_err), 0);
        req_pulse; hit_sp(2); collect(2, 1);
        rs_valid = 1'b1; rs_data = hdr(0, 1); tick; rs_valid = 1'b0;
        chk("R10 err set again", 32'(rs_err), 1);
        go_cmd = 1'b1; tick; go_cmd = 1'b0;
        chk("R10 err cleared by start", 32'(rs_err), 0);
        chk("R1 start after error", 32'(task_run), 1);
    endtask

    task automatic t_max;
        req_pulse; hit_sp(3);
        collect(3, 15);
        do_restore(3, 15);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset;
        t_stray_sp;
        t_save_basic;
        t_restore_basic;
        t_zero;
        t_mismatch;
        t_max;
        repeat (3) tick;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule